// File: doc/BRIEF.md
# ADC Scan Sequencer with Single-Channel Preemption

This block sequences an analog-to-digital conversion engine. Software arms a one-shot scan that converts channels 0 up to a programmed last channel in ascending order. Each result lands in that channel's 10-bit result register. While the scan runs, a single-channel request can cut in on any channel, including one outside the scan set. The sequencer aborts the conversion in flight and runs the requested channel. It then converts the interrupted channel again from the beginning and carries on with the scan from there.

A forced request comes from software or from hardware, as chosen by a trigger-select field. In software mode, a start bit begins a plain forced conversion. In comparison mode, writing a reference value begins the forced conversion instead. In hardware mode, a rising edge on either the trigger pin or an alternative event input begins it, and a field chooses between the two. The engine is driven through a start / cancel / done / result handshake. A completion pulse is raised either when the forced conversion finishes or when the scan finishes, and instance 0 also mirrors this pulse onto a DMA request.

Top module: `adc_scan_sequencer`

## Requirements
- R1: After reset, `busy`, `conv_start`, `conv_cancel`, `irq_req` and `dma_req` are low, and every result register and `cmp_data` read zero.
- R2: Writing address 0 with bit 0 set starts a one-shot scan, with the last channel taken from bits [6:4]. The scan issues conversions on channels 0..last in ascending order, stores each result in that channel's slot of `res_flat` (slot j at bits [10j+9:10j]), and stops after the last channel.
- R3: `busy` is high from the scan's first conversion start until the last scan result is stored, and this includes the time spent on a forced conversion. Conversions are started only while `busy` is high.
- R4: An accepted forced request pulses `conv_cancel` for one cycle. On the next cycle `conv_start` is issued with `conv_ch` set to the forced channel (address 1 bits [10:8]) and `conv_cmp` set to the comparison-mode bit (address 1 bit 1).
- R5: The cancelled channel's result is never stored. After the forced conversion, that channel is converted again from the start, and the scan goes on from it, which makes two extra engine starts in total. If a forced request meets a scan done in the same cycle, the request wins and that result is discarded.
- R6: In plain mode (address 1 bit 1 = 0), the forced result is written to the forced channel's result register. In comparison mode, it is written only to `cmp_data`, and every result register keeps its value.
- R7: With software selected (address 1 bit 2 = 0), a write to address 1 with bit 0 set and bit 1 clear starts a forced conversion. In comparison mode, a write to address 2 starts it instead, and its bits [9:0] appear on `conv_ref`.
- R8: With hardware selected (address 1 bit 2 = 1), a rising edge on `trig_pin` starts a forced conversion when address 1 bit 3 is 0, and a rising edge on `trig_evt` starts one when that bit is 1.
- R9: A trigger of the deselected kind has no effect. This covers a software start while hardware is selected, `trig_pin` while software is selected, and the unselected hardware input.
- R10: A forced request has no effect while a forced conversion is already in progress, and none while no scan is running.
- R11: `irq_req` is a one-cycle pulse. With address 1 bit 4 = 0, it fires once per forced conversion completed. With bit 4 = 1, it fires once when the scan's last result is stored.
- R12: On instance 0 (`INST_ID` = 0), `dma_req` pulses together with `irq_req`. On any other instance, it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address (0 scan, 1 forced control, 2 reference) |
| wr_data | input | DATA_W | Register write data |
| trig_pin | input | 1 | External hardware trigger, asynchronous |
| trig_evt | input | 1 | Alternative hardware event, asynchronous |
| conv_start | output | 1 | Start pulse to the conversion engine |
| conv_cancel | output | 1 | Abort pulse to the conversion engine |
| conv_ch | output | CH_W | Channel for the conversion being started |
| conv_cmp | output | 1 | Started conversion is a comparison |
| conv_ref | output | RES_W | Stored comparison reference |
| conv_done | input | 1 | Engine finished a conversion |
| conv_result | input | RES_W | Engine result, valid with `conv_done` |
| busy | output | 1 | Scan in progress |
| res_flat | output | NCH*RES_W | Per-channel result registers, channel j at [RES_W*j +: RES_W] |
| cmp_data | output | RES_W | Comparison result register |
| irq_req | output | 1 | Completion pulse |
| dma_req | output | 1 | DMA request pulse (instance 0 only) |

## Verification
Plain scans are swept over every last-channel value, which shows the ordering and the stop point on their own. The preemption sweep puts a forced request on each scan position against every forced channel, both inside and outside the scan set. It uses an engine whose result encodes the channel and a start serial number, so a stored cancelled result, a missing reconversion or a scan that resumes in the wrong place each leave a distinct value in the result registers. Comparison-mode and hardware-trigger runs show the routing to `cmp_data` and the selection between the two sources. Runs with deselected triggers, doubled requests and requests while idle must leave the results, the start count and the pulse count the same as a run with no request at all.

// File: rtl/adseq_pkg.sv
package adseq_pkg;

   // Sequencer states
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SCAN_GO,
      ST_SCAN_WAIT,
      ST_CANCEL,
      ST_FORCE_GO,
      ST_FORCE_WAIT
   } seq_state_t;

   // Register addresses
   localparam logic [1:0] A_SCAN  = 2'd0;
   localparam logic [1:0] A_FORCE = 2'd1;
   localparam logic [1:0] A_REF   = 2'd2;

   // Field positions
   localparam int B_GO       = 0;
   localparam int B_LAST_LSB = 4;
   localparam int B_START    = 0;
   localparam int B_CMP      = 1;
   localparam int B_HW       = 2;
   localparam int B_SRC      = 3;
   localparam int B_IRQSCAN  = 4;
   localparam int B_FCH_LSB  = 8;

   typedef struct packed {
      logic cmp;
      logic hw;
      logic src;
      logic irq_scan;
   } force_cfg_t;

endpackage

// File: rtl/adseq_trig_sync.sv
module adseq_trig_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] rise
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("adseq_trig_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         logic [STAGES:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else        sh_q <= {sh_q[STAGES-1:0], din[i]};
         end
         assign rise[i] = sh_q[STAGES-1] & ~sh_q[STAGES];
      end
   endgenerate

endmodule

// File: rtl/adseq_cfg_regs.sv
module adseq_cfg_regs
   import adseq_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int CH_W   = 3,
   parameter int RES_W  = 10,
   parameter int DATA_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              scan_go,
   output logic [CH_W-1:0]   scan_last,
   output logic [CH_W-1:0]   force_ch,
   output force_cfg_t        cfg,
   output logic [RES_W-1:0]  ref_val,
   output logic              sw_force
);

   localparam logic [CH_W-1:0] MAX_CH = CH_W'(NCH - 1);

   logic [CH_W-1:0] last_raw, fch_raw, last_cl, fch_cl;
   logic            wr_scan, wr_force, wr_ref, sw_hit;

   assign wr_scan  = wr_en && (wr_addr == A_SCAN);
   assign wr_force = wr_en && (wr_addr == A_FORCE);
   assign wr_ref   = wr_en && (wr_addr == A_REF);

   assign last_raw = wr_data[B_LAST_LSB +: CH_W];
   assign fch_raw  = wr_data[B_FCH_LSB +: CH_W];
   assign last_cl  = (last_raw > MAX_CH) ? MAX_CH : last_raw;
   assign fch_cl   = (fch_raw > MAX_CH) ? MAX_CH : fch_raw;

   // software start: plain-mode start bit, or reference write in comparison mode
   assign sw_hit = (wr_force && wr_data[B_START] && !wr_data[B_HW] && !wr_data[B_CMP])
                || (wr_ref && !cfg.hw && cfg.cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scan_go   <= 1'b0;
         sw_force  <= 1'b0;
         scan_last <= '0;
         force_ch  <= '0;
         cfg       <= '0;
         ref_val   <= '0;
      end else begin
         scan_go  <= wr_scan && wr_data[B_GO];
         sw_force <= sw_hit;
         if (wr_scan) scan_last <= last_cl;
         if (wr_force) begin
            force_ch     <= fch_cl;
            cfg.cmp      <= wr_data[B_CMP];
            cfg.hw       <= wr_data[B_HW];
            cfg.src      <= wr_data[B_SRC];
            cfg.irq_scan <= wr_data[B_IRQSCAN];
         end
         if (wr_ref) ref_val <= wr_data[RES_W-1:0];
      end
   end

endmodule

// File: rtl/adseq_fsm.sv
module adseq_fsm
   import adseq_pkg::*;
#(
   parameter int CH_W = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            scan_go,
   input  logic [CH_W-1:0] scan_last,
   input  logic            force_req,
   input  logic [CH_W-1:0] force_ch,
   input  logic            force_cmp,
   input  logic            conv_done,
   output logic            conv_start,
   output logic            conv_cancel,
   output logic [CH_W-1:0] conv_ch,
   output logic            conv_cmp,
   output logic            busy,
   output logic            wr_res,
   output logic            wr_cmp,
   output logic [CH_W-1:0] wr_idx,
   output logic            force_fin,
   output logic            scan_fin
);

   seq_state_t      st_q, st_d;
   logic [CH_W-1:0] cur_q, cur_d, last_q, last_d, fch_q, fch_d;
   logic            fcmp_q, fcmp_d;
   logic            in_scan, take_force, scan_step, force_step;

   assign in_scan    = (st_q == ST_SCAN_GO) || (st_q == ST_SCAN_WAIT);
   assign take_force = in_scan && force_req;
   assign scan_step  = (st_q == ST_SCAN_WAIT) && conv_done && !force_req;
   assign force_step = (st_q == ST_FORCE_WAIT) && conv_done;

   always_comb begin
      st_d   = st_q;
      cur_d  = cur_q;
      last_d = last_q;
      fch_d  = fch_q;
      fcmp_d = fcmp_q;
      unique case (st_q)
         ST_IDLE: begin
            if (scan_go) begin
               st_d   = ST_SCAN_GO;
               cur_d  = '0;
               last_d = scan_last;
            end
         end
         ST_SCAN_GO: begin
            st_d = ST_SCAN_WAIT;
         end
         ST_SCAN_WAIT: begin
            if (scan_step) begin
               if (cur_q == last_q) st_d = ST_IDLE;
               else begin
                  st_d  = ST_SCAN_GO;
                  cur_d = cur_q + 1'b1;
               end
            end
         end
         ST_CANCEL:     st_d = ST_FORCE_GO;
         ST_FORCE_GO:   st_d = ST_FORCE_WAIT;
         ST_FORCE_WAIT: if (force_step) st_d = ST_SCAN_GO;
         default:       st_d = ST_IDLE;
      endcase
      if (take_force) begin
         st_d   = ST_CANCEL;
         fch_d  = force_ch;
         fcmp_d = force_cmp;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         cur_q  <= '0;
         last_q <= '0;
         fch_q  <= '0;
         fcmp_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cur_q  <= cur_d;
         last_q <= last_d;
         fch_q  <= fch_d;
         fcmp_q <= fcmp_d;
      end
   end

   assign conv_start  = (st_q == ST_SCAN_GO) || (st_q == ST_FORCE_GO);
   assign conv_cancel = (st_q == ST_CANCEL);
   assign conv_ch     = (st_q == ST_FORCE_GO) ? fch_q : cur_q;
   assign conv_cmp    = (st_q == ST_FORCE_GO) && fcmp_q;
   assign busy        = (st_q != ST_IDLE);
   assign wr_res      = scan_step || (force_step && !fcmp_q);
   assign wr_cmp      = force_step && fcmp_q;
   assign wr_idx      = (st_q == ST_FORCE_WAIT) ? fch_q : cur_q;
   assign force_fin   = force_step;
   assign scan_fin    = scan_step && (cur_q == last_q);

endmodule

// File: rtl/adseq_result_bank.sv
module adseq_result_bank #(
   parameter int NCH   = 8,
   parameter int CH_W  = 3,
   parameter int RES_W = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_res,
   input  logic                 wr_cmp,
   input  logic [CH_W-1:0]      wr_idx,
   input  logic [RES_W-1:0]     din,
   output logic [NCH*RES_W-1:0] res_flat,
   output logic [RES_W-1:0]     cmp_q
);

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_slot
         logic [RES_W-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  slot_q <= '0;
            else if (wr_res && (wr_idx == CH_W'(c)))     slot_q <= din;
         end
         assign res_flat[c*RES_W +: RES_W] = slot_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cmp_q <= '0;
      else if (wr_cmp) cmp_q <= din;
   end

endmodule

// File: rtl/adc_scan_sequencer.sv
module adc_scan_sequencer
   import adseq_pkg::*;
#(
   parameter int NCH         = 8,
   parameter int RES_W       = 10,
   parameter int DATA_W      = 11,
   parameter int SYNC_STAGES = 2,
   parameter int INST_ID     = 0,
   localparam int CH_W       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [1:0]           wr_addr,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic                 trig_pin,
   input  logic                 trig_evt,
   output logic                 conv_start,
   output logic                 conv_cancel,
   output logic [CH_W-1:0]      conv_ch,
   output logic                 conv_cmp,
   output logic [RES_W-1:0]     conv_ref,
   input  logic                 conv_done,
   input  logic [RES_W-1:0]     conv_result,
   output logic                 busy,
   output logic [NCH*RES_W-1:0] res_flat,
   output logic [RES_W-1:0]     cmp_data,
   output logic                 irq_req,
   output logic                 dma_req
);

   generate
      if (NCH < 2) begin : g_bad_nch
         $error("adc_scan_sequencer: NCH must be at least 2");
      end
      if (B_FCH_LSB + CH_W > DATA_W || B_LAST_LSB + CH_W > B_FCH_LSB) begin : g_bad_fields
         $error("adc_scan_sequencer: channel fields do not fit the write word");
      end
      if (RES_W > DATA_W) begin : g_bad_resw
         $error("adc_scan_sequencer: RES_W exceeds DATA_W");
      end
      if (INST_ID < 0 || INST_ID > 1) begin : g_bad_inst
         $error("adc_scan_sequencer: INST_ID must be 0 or 1");
      end
   endgenerate

   logic            scan_go, sw_force, hw_force, force_req;
   logic [CH_W-1:0] scan_last, force_ch, wr_idx;
   force_cfg_t      cfg;
   logic [1:0]      hw_rise;
   logic            wr_res, wr_cmp, force_fin, scan_fin, irq_q;

   adseq_cfg_regs #(
      .NCH(NCH), .CH_W(CH_W), .RES_W(RES_W), .DATA_W(DATA_W)
   ) i_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .scan_go(scan_go), .scan_last(scan_last), .force_ch(force_ch), .cfg(cfg),
      .ref_val(conv_ref), .sw_force(sw_force)
   );

   adseq_trig_sync #(
      .WIDTH(2), .STAGES(SYNC_STAGES)
   ) i_sync (
      .clk(clk), .rst_n(rst_n), .din({trig_evt, trig_pin}), .rise(hw_rise)
   );

   // hardware source: bit 0 pin, bit 1 alternative event
   assign hw_force  = cfg.hw && (cfg.src ? hw_rise[1] : hw_rise[0]);
   assign force_req = sw_force || hw_force;

   adseq_fsm #(
      .CH_W(CH_W)
   ) i_fsm (
      .clk(clk), .rst_n(rst_n), .scan_go(scan_go), .scan_last(scan_last),
      .force_req(force_req), .force_ch(force_ch), .force_cmp(cfg.cmp),
      .conv_done(conv_done), .conv_start(conv_start), .conv_cancel(conv_cancel),
      .conv_ch(conv_ch), .conv_cmp(conv_cmp), .busy(busy), .wr_res(wr_res),
      .wr_cmp(wr_cmp), .wr_idx(wr_idx), .force_fin(force_fin), .scan_fin(scan_fin)
   );

   adseq_result_bank #(
      .NCH(NCH), .CH_W(CH_W), .RES_W(RES_W)
   ) i_bank (
      .clk(clk), .rst_n(rst_n), .wr_res(wr_res), .wr_cmp(wr_cmp), .wr_idx(wr_idx),
      .din(conv_result), .res_flat(res_flat), .cmp_q(cmp_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= cfg.irq_scan ? scan_fin : force_fin;
   end
   assign irq_req = irq_q;

   generate
      if (INST_ID == 0) begin : g_dma
         assign dma_req = irq_q;
      end else begin : g_no_dma
         assign dma_req = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/adseq_checker.sv
module adseq_checker #(
   parameter int CH_W    = 3,
   parameter int INST_ID = 0
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_start,
   input logic            conv_cancel,
   input logic [CH_W-1:0] conv_ch,
   input logic            busy,
   input logic            irq_req,
   input logic            dma_req
);

   // R2: a scan opens with a start on channel 0
   p_scan_from_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> (conv_start && conv_ch == '0));

   // R3: starts happen only inside a scan
   p_start_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |-> busy);

   // R4: cancel and start never coincide
   p_start_cancel_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(conv_start && conv_cancel));

   // R4: a cancel is followed by the forced start
   p_cancel_then_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      conv_cancel |=> conv_start);

   // R11: completion is a single-cycle pulse
   p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req |=> !irq_req);

   // R12: no DMA request on instances other than 0
   p_dma_absent_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (INST_ID != 0) |-> !dma_req);

endmodule

bind adc_scan_sequencer adseq_checker #(
   .CH_W(CH_W), .INST_ID(INST_ID)
) i_adseq_checker (
   .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_cancel(conv_cancel),
   .conv_ch(conv_ch), .busy(busy), .irq_req(irq_req), .dma_req(dma_req)
);

// File: tb/test_adc_scan_sequencer.sv
module test_adc_scan_sequencer;

   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 8;
   localparam int RES_W = 10;
   localparam int LAT   = 8;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic                 wr_en = 1'b0;
   logic [1:0]           wr_addr = '0;
   logic [10:0]          wr_data = '0;
   logic                 trig_pin = 1'b0, trig_evt = 1'b0;
   logic                 conv_done = 1'b0;
   logic [RES_W-1:0]     conv_result = '0;
   logic                 conv_start, conv_cancel, conv_cmp, busy, irq_req, dma_req;
   logic [2:0]           conv_ch;
   logic [RES_W-1:0]     conv_ref, cmp_data;
   logic [NCH*RES_W-1:0] res_flat;
   logic                 b_start, b_cancel, b_cmp, b_busy, b_irq, b_dma;
   logic [2:0]           b_ch;
   logic [RES_W-1:0]     b_ref, b_cmpd;
   logic [NCH*RES_W-1:0] b_res;

   int n_chk = 0, n_bad = 0, cycles = 0;
   logic [RES_W-1:0] exp_res [NCH];
   logic [RES_W-1:0] exp_cmp;

   always #(CLK_PERIOD/2) clk = ~clk;

   adc_scan_sequencer #(.INST_ID(0)) i_adc_scan_sequencer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .trig_pin(trig_pin), .trig_evt(trig_evt), .conv_start(conv_start),
      .conv_cancel(conv_cancel), .conv_ch(conv_ch), .conv_cmp(conv_cmp),
      .conv_ref(conv_ref), .conv_done(conv_done), .conv_result(conv_result),
      .busy(busy), .res_flat(res_flat), .cmp_data(cmp_data), .irq_req(irq_req),
      .dma_req(dma_req));

   adc_scan_sequencer #(.INST_ID(1)) i_adc_scan_sequencer_b (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .trig_pin(trig_pin), .trig_evt(trig_evt), .conv_start(b_start),
      .conv_cancel(b_cancel), .conv_ch(b_ch), .conv_cmp(b_cmp),
      .conv_ref(b_ref), .conv_done(conv_done), .conv_result(conv_result),
      .busy(b_busy), .res_flat(b_res), .cmp_data(b_cmpd), .irq_req(b_irq),
      .dma_req(b_dma));

   // fixed-latency engine: result = {channel, start serial}
   logic       eng_clr = 1'b0;
   logic       eng_act = 1'b0;
   int         eng_cnt = 0;
   int         eng_serial = 0;
   always @(posedge clk) begin
      if (eng_clr) begin
         eng_serial <= 0; eng_act <= 1'b0; conv_done <= 1'b0;
      end else begin
         conv_done <= 1'b0;
         if (conv_cancel) eng_act <= 1'b0;
         else if (conv_start) begin
            eng_act     <= 1'b1;
            eng_cnt     <= LAT;
            conv_result <= {conv_ch, 7'(eng_serial)};
            eng_serial  <= eng_serial + 1;
         end else if (eng_act) begin
            if (eng_cnt == 1) begin conv_done <= 1'b1; eng_act <= 1'b0; end
            else eng_cnt <= eng_cnt - 1;
         end
      end
   end

   function automatic logic [RES_W-1:0] enc(input int ch, input int s);
      return {3'(ch), 7'(s)};
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary_and_end();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
         summary_and_end();
      end
   end

   task automatic wr(input logic [1:0] a, input logic [10:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic check_results(input string req);
      for (int j = 0; j < NCH; j++)
         chk(res_flat[j*RES_W +: RES_W] == exp_res[j], req, $sformatf("res[%0d]", j),
             int'(res_flat[j*RES_W +: RES_W]), int'(exp_res[j]));
      chk(cmp_data == exp_cmp, req, "cmp_data", int'(cmp_data), int'(exp_cmp));
   endtask

   // mode: 0 sw plain, 1 sw comparison, 2 hw pin, 3 hw event (comparison)
   //       4 sw start under hw select, 5 pin under sw select, 6 event under pin select
   task automatic run_case(input int last, input int k, input int fch, input int mode,
                           input bit irq_scan, input bit dbl);
      int starts = 0, cancels = 0, irqs = 0, dmas = 0, irqs_b = 0, dmas_b = 0;
      int inj_at = -1, dbl_at = -1, tail = -1, pin_cnt = 0, evt_cnt = 0;
      bit seen = 0, injected = 0, chk_next = 0, forced, cmp, hw, src;
      logic [10:0] ctl;
      logic [9:0]  refv;
      string rq;
      forced = (k >= 0) && (mode <= 3);
      cmp    = (mode == 1) || (mode == 3);
      hw     = (mode == 2) || (mode == 3) || (mode == 4) || (mode == 6);
      src    = (mode == 3);
      refv   = 10'h155 ^ 10'(fch);
      rq     = (mode >= 4) ? "R9" : "R5";
      ctl    = {3'(fch), 3'b000, irq_scan, src, hw, cmp, 1'b0};
      @(negedge clk); eng_clr = 1'b1;
      @(negedge clk); eng_clr = 1'b0;
      wr(2'd1, ctl);
      wr(2'd0, {4'b0, 3'(last), 3'b000, 1'b1});
      for (int t = 0; t < 600; t++) begin
         @(negedge clk);
         wr_en = 1'b0;
         if (pin_cnt > 0) begin pin_cnt--; if (pin_cnt == 0) trig_pin = 1'b0; end
         if (evt_cnt > 0) begin evt_cnt--; if (evt_cnt == 0) trig_evt = 1'b0; end
         if (chk_next) begin
            chk(conv_start == 1'b1, "R4", "forced start", int'(conv_start), 1);
            chk(conv_ch == 3'(fch), "R4", "forced channel", int'(conv_ch), fch);
            chk(conv_cmp == cmp, "R4", "forced cmp flag", int'(conv_cmp), int'(cmp));
            chk(busy == 1'b1, "R3", "busy during forced", int'(busy), 1);
            chk_next = 0;
         end
         if (conv_start) starts++;
         if (conv_cancel) begin
            cancels++; chk_next = 1;
            if (dbl) dbl_at = t + 2;
         end
         if (irq_req) irqs++;
         if (dma_req) dmas++;
         if (b_irq) irqs_b++;
         if (b_dma) dmas_b++;
         if (busy) seen = 1;
         if (k >= 0 && !injected && conv_start && conv_ch == 3'(k) && busy) begin
            injected = 1; inj_at = t + 1;
         end
         if (t == inj_at) begin
            case (mode)
               0, 4:    begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = ctl | 11'd1; end
               1:       begin wr_en = 1'b1; wr_addr = 2'd2; wr_data = {1'b0, refv}; end
               2, 5:    begin trig_pin = 1'b1; pin_cnt = 3; end
               default: begin trig_evt = 1'b1; evt_cnt = 3; end
            endcase
         end
         if (t == dbl_at) begin wr_en = 1'b1; wr_addr = 2'd1; wr_data = ctl | 11'd1; end
         if (seen && !busy && tail < 0) tail = 3;
         if (tail == 0) break;
         if (tail > 0) tail--;
      end
      wr_en = 1'b0; trig_pin = 1'b0; trig_evt = 1'b0;
      chk(tail == 0, "R2", "scan completion", tail, 0);
      // expected state
      for (int j = 0; j <= last; j++)
         exp_res[j] = enc(j, (forced && j >= k) ? j + 2 : j);
      if (forced && !cmp && !(fch >= k && fch <= last)) exp_res[fch] = enc(fch, k + 1);
      if (forced && cmp) exp_cmp = enc(fch, k + 1);
      check_results(forced ? (cmp ? "R6" : "R5") : ((mode >= 4) ? "R9" : "R2"));
      chk(starts == last + 1 + (forced ? 2 : 0), rq, "start count", starts,
          last + 1 + (forced ? 2 : 0));
      chk(cancels == (forced ? 1 : 0), rq, "cancel count", cancels, forced ? 1 : 0);
      chk(irqs == ((irq_scan || forced) ? 1 : 0), "R11", "irq pulses", irqs,
          (irq_scan || forced) ? 1 : 0);
      chk(dmas == irqs, "R12", "dma pulses inst0", dmas, irqs);
      chk(irqs_b == irqs && dmas_b == 0, "R12", "dma pulses inst1", dmas_b, 0);
      chk(busy == 1'b0, "R3", "busy after scan", int'(busy), 0);
      if (mode == 1 && forced)
         chk(conv_ref == refv, "R7", "conv_ref", int'(conv_ref), int'(refv));
      if (mode == 2 || mode == 3)
         chk(cancels == 1, "R8", "hw trigger accepted", cancels, 1);
      if (dbl)
         chk(starts == last + 3, "R10", "second forced request", starts, last + 3);
   endtask

   initial begin
      for (int j = 0; j < NCH; j++) exp_res[j] = '0;
      exp_cmp = '0;
      repeat (5) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
      chk(conv_start == 1'b0 && conv_cancel == 1'b0, "R1", "engine strobes",
          int'(conv_start), 0);
      chk(irq_req == 1'b0 && dma_req == 1'b0, "R1", "pulses", int'(irq_req), 0);
      check_results("R1");
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R2: plain scans for every last channel
      for (int l = 0; l < NCH; l++) run_case(l, -1, 0, 0, 1'b1, 1'b0);
      // R4 R5: plain forced sweep over position and forced channel
      for (int k = 0; k < 4; k++)
         for (int f = 0; f < NCH; f++) run_case(3, k, f, 0, 1'b0, 1'b0);
      // R6 R7: comparison mode via reference write
      for (int k = 0; k < 6; k++) run_case(5, k, (k + 3) % NCH, 1, 1'b0, 1'b0);
      // R8: hardware sources
      run_case(7, 2, 6, 2, 1'b1, 1'b0);
      run_case(7, 4, 1, 2, 1'b0, 1'b0);
      run_case(4, 0, 7, 3, 1'b0, 1'b0);
      run_case(4, 4, 3, 3, 1'b1, 1'b0);
      // R9: deselected triggers
      run_case(3, 1, 5, 4, 1'b1, 1'b0);
      run_case(3, 2, 5, 5, 1'b1, 1'b0);
      run_case(3, 0, 5, 6, 1'b0, 1'b0);
      // R10: second request during a forced conversion
      run_case(6, 3, 2, 0, 1'b0, 1'b1);
      // R10: request while idle
      begin
         int st = 0;
         wr(2'd1, {3'd2, 3'b000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1});
         for (int t = 0; t < 15; t++) begin
            @(negedge clk);
            if (conv_start) st++;
         end
         chk(st == 0, "R10", "start while idle", st, 0);
         chk(busy == 1'b0, "R10", "busy while idle", int'(busy), 0);
         check_results("R10");
      end
      summary_and_end();
   end

endmodule